// File: doc/BRIEF.md
# Rolling Shutter Readout Sequencer

This block produces the row and column timing for an image sensor read with an electronic rolling shutter. It runs on one system clock. It keeps two row pointers. The read pointer walks the rows being digitised. The reset pointer walks the rows being cleared. Exposure is set by how many lines separate the two pointers.

Every line has the same three phases. It opens with a row-clock pulse and a blanking interval. A fixed startup latency follows. Then a pixel-valid window runs over the programmed column range. End-of-line marks the last pixel of each line. End-of-frame is added on the last line of the window, and the read pointer then returns to the start row.

Window, integration, subsampling, delay and non-destructive mode settings are captured at the start of each frame. The pixel-valid, column, end-of-line and end-of-frame outputs can be pushed later by a programmable number of clocks. This lets them line up with a downstream data path.

Top module: `rolling_shutter_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until run_i is raised, every output is low or zero. Asserting rst_ni clears the outputs at once, even in the middle of a frame.
- R2: Each line starts with a one-cycle row_clk_o pulse. blank_o is high for BLANK_CYC (default 8) cycles starting with that pulse. With zero delay, pix_valid_o is low for the whole blanking interval.
- R3: With zero delay, pix_valid_o rises PIX_LAT (default 5) cycles after blanking ends, that is BLANK_CYC+PIX_LAT cycles after row_clk_o. It stays high for exactly the captured pixel count, and the next line's row_clk_o follows the last pixel at once.
- R4: Across a line, pix_col_o takes the values col_start + k*step_x (modulo 2048) for k = 0, 1, 2 and so on. The 3-bit subsampling code maps 0, 1, 2 and 3 to steps 1, 2, 4 and 8. Codes 4 to 7 give step 1.
- R5: At the row_clk_o of line l, rd_row_o equals row_start + l*step_y (modulo 4096). The same code mapping applies to step_y. rd_sync_o pulses together with row_clk_o on line 0 only.
- R6: eol_o is high on the last valid pixel of every line. eof_o is high together with eol_o on the last line of the frame only.
- R7: pix_valid_o, pix_col_o, eol_o and eof_o are delayed by the captured delay value, from 0 to 15 cycles. row_clk_o, rd_sync_o, blank_o and the pointers are not delayed.
- R8: rst_sync_o pulses at the row_clk_o of the line whose index since rd_sync_o equals the integration value, and rst_row_o is loaded with row_start. After that it advances by step_y on each line. If the integration value is not below the line count, rst_sync_o never pulses.
- R9: rst_en_o is high while the reset pointer is walking rows. It is held low when non-destructive mode (ndr_i = 1) was captured.
- R10: A pixel count of 0 is read as 1, and a count above COL_MAX (1111) is read as 1111. A line count of 0 is read as 1.
- R11: All settings are captured in the cycle a frame starts. Changing the inputs during a frame has no effect on that frame.
- R12: When run_i is high at the end of a frame, the next frame starts at once. When it is low, the current frame completes and the block then idles with no further row_clk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start frames and keep running |
| row_start_i | input | 12 | First row of the window |
| row_count_i | input | 12 | Lines per frame |
| col_start_i | input | 11 | First column of the window |
| col_count_i | input | 11 | Pixels per line |
| int_lines_i | input | 12 | Line index at which the reset pointer is synced |
| sub_x_i | input | 3 | Column subsampling code |
| sub_y_i | input | 3 | Row subsampling code |
| delay_i | input | 4 | Pixel output delay in clocks |
| ndr_i | input | 1 | Non-destructive readout, suppresses row reset |
| rd_sync_o | output | 1 | Read pointer loaded with start row |
| rst_sync_o | output | 1 | Reset pointer loaded with start row |
| row_clk_o | output | 1 | Line start pulse |
| rd_row_o | output | 12 | Read pointer row address |
| rst_row_o | output | 12 | Reset pointer row address |
| rst_en_o | output | 1 | Reset pointer is clearing rows |
| blank_o | output | 1 | Row blanking interval |
| pix_valid_o | output | 1 | Pixel valid (delayed) |
| pix_col_o | output | 11 | Column of the current pixel (delayed) |
| eol_o | output | 1 | Last pixel of a line (delayed) |
| eof_o | output | 1 | Last pixel of a frame (delayed) |

## Verification
rd_sync_o, row_clk_o and blank_o follow on the first clock after a frame or line is started. The line period is BLANK_CYC + PIX_LAT + pixel count. The pixel outputs arrive BLANK_CYC + PIX_LAT + delay cycles after row_clk_o. The bench fixes cycle zero at the first sample where rd_sync_o is high. For every later sample it works out the expected line, phase and pixel index from that count alone. Each output is compared on the falling edge in the exact cycle it is due.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 11;
  localparam int DLY_W  = 4;
  localparam int SUB_W  = 3;
  localparam int STEP_W = 4;
  localparam logic [COL_W-1:0] COL_RST = 11'd512;

  typedef enum logic [1:0] {PH_IDLE, PH_BLANK, PH_LAT, PH_PIX} phase_e;

  typedef struct packed {
    logic [ROW_W-1:0] row_start;
    logic [ROW_W-1:0] row_count;
    logic [ROW_W-1:0] int_lines;
    logic [COL_W-1:0] col_start;
    logic [COL_W-1:0] col_count;
    logic [SUB_W-1:0] sub_x;
    logic [SUB_W-1:0] sub_y;
    logic [DLY_W-1:0] delay;
    logic             ndr;
  } cfg_t;

  typedef struct packed {
    logic             pv;
    logic             eol;
    logic             eof;
    logic [COL_W-1:0] col;
  } tag_t;

  function automatic logic [STEP_W-1:0] step_of(input logic [SUB_W-1:0] code);
    case (code)
      3'd1:    step_of = 4'd2;
      3'd2:    step_of = 4'd4;
      3'd3:    step_of = 4'd8;
      default: step_of = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/rs_line_timer.sv
module rs_line_timer import rs_pkg::*; #(
  parameter int BLANK_CYC = 8,
  parameter int PIX_LAT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              last_line_i,
  input  logic [COL_W-1:0]  col_start_i,
  input  logic [COL_W-1:0]  col_last_i,
  input  logic [STEP_W-1:0] step_x_i,
  output logic              frame_load_o,
  output logic              line_adv_o,
  output logic              row_clk_o,
  output logic              rd_sync_o,
  output logic              blank_o,
  output logic              pix_o,
  output logic              line_end_o,
  output logic [COL_W-1:0]  col_o
);
  localparam int CNT_MAX = (BLANK_CYC > PIX_LAT) ? BLANK_CYC : PIX_LAT;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);
  localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] LAT_END   = CNT_W'(PIX_LAT - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] pix_q;
  logic [COL_W-1:0] col_q;
  logic             row_clk_q, rd_sync_q;
  logic             line_end, frame_load, line_adv;

  always_comb begin
    line_end   = (ph_q == PH_PIX) && (pix_q == col_last_i);
    frame_load = run_i && ((ph_q == PH_IDLE) || (line_end && last_line_i));
    line_adv   = ((ph_q == PH_IDLE) && run_i) || (line_end && (run_i || !last_line_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      pix_q     <= '0;
      col_q     <= '0;
      row_clk_q <= 1'b0;
      rd_sync_q <= 1'b0;
    end else begin
      row_clk_q <= line_adv;
      rd_sync_q <= frame_load;
      case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (line_adv) ph_q <= PH_BLANK;
        end
        PH_BLANK: begin
          if (cnt_q == BLANK_END) begin
            ph_q  <= PH_LAT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_LAT: begin
          if (cnt_q == LAT_END) begin
            ph_q  <= PH_PIX;
            cnt_q <= '0;
            pix_q <= '0;
            col_q <= col_start_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PIX: begin
          if (line_end) begin
            ph_q  <= line_adv ? PH_BLANK : PH_IDLE;
            cnt_q <= '0;
          end else begin
            pix_q <= pix_q + 1'b1;
            col_q <= col_q + COL_W'(step_x_i);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign frame_load_o = frame_load;
  assign line_adv_o   = line_adv;
  assign row_clk_o    = row_clk_q;
  assign rd_sync_o    = rd_sync_q;
  assign blank_o      = (ph_q == PH_BLANK);
  assign pix_o        = (ph_q == PH_PIX);
  assign line_end_o   = line_end;
  assign col_o        = col_q;
endmodule

// File: rtl/rs_row_ptrs.sv
module rs_row_ptrs import rs_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_adv_i,
  input  logic              frame_load_i,
  input  logic [ROW_W-1:0]  start_i,
  input  logic [ROW_W-1:0]  int_i,
  input  logic [ROW_W-1:0]  row_last_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              last_line_o,
  output logic [ROW_W-1:0]  rd_row_o,
  output logic [ROW_W-1:0]  rst_row_o,
  output logic              rst_act_o,
  output logic              rst_sync_o
);
  logic [ROW_W-1:0] rd_idx_q, rd_row_q, ls_q, ls_n;
  logic [ROW_W-1:0] rst_idx_q, rst_row_q;
  logic             rst_act_q, rst_sync_q;

  assign ls_n = frame_load_i ? '0 : ls_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q   <= '0;
      rd_row_q   <= '0;
      ls_q       <= '0;
      rst_idx_q  <= '0;
      rst_row_q  <= '0;
      rst_act_q  <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_sync_q <= 1'b0;
      if (line_adv_i) begin
        rd_idx_q <= frame_load_i ? '0 : rd_idx_q + 1'b1;
        rd_row_q <= frame_load_i ? start_i : rd_row_q + ROW_W'(step_i);
        ls_q     <= ls_n;
        // reset pointer resyncs once the read side has advanced int_i lines
        if (ls_n == int_i) begin
          rst_sync_q <= 1'b1;
          rst_idx_q  <= '0;
          rst_row_q  <= start_i;
          rst_act_q  <= 1'b1;
        end else if (rst_act_q) begin
          if (rst_idx_q == row_last_i) begin
            rst_act_q <= 1'b0;
          end else begin
            rst_idx_q <= rst_idx_q + 1'b1;
            rst_row_q <= rst_row_q + ROW_W'(step_i);
          end
        end
      end
    end
  end

  assign last_line_o = (rd_idx_q == row_last_i);
  assign rd_row_o    = rd_row_q;
  assign rst_row_o   = rst_row_q;
  assign rst_act_o   = rst_act_q;
  assign rst_sync_o  = rst_sync_q;
endmodule

// File: rtl/rs_out_delay.sv
module rs_out_delay import rs_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DLY_W-1:0] sel_i,
  input  tag_t             tag_i,
  output tag_t             tag_o
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  tag_t tap [DEPTH+1];
  assign tap[0] = tag_i;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    tag_t stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= tap[g-1];
    end
    assign tap[g] = stage_q;
  end

  assign tag_o = tap[sel_i];
endmodule

// File: rtl/rolling_shutter_seq.sv
module rolling_shutter_seq import rs_pkg::*; #(
  parameter int               BLANK_CYC = 8,
  parameter int               PIX_LAT   = 5,
  parameter logic [COL_W-1:0] COL_MAX   = 11'd1111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ROW_W-1:0] row_start_i,
  input  logic [ROW_W-1:0] row_count_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic [COL_W-1:0] col_count_i,
  input  logic [ROW_W-1:0] int_lines_i,
  input  logic [SUB_W-1:0] sub_x_i,
  input  logic [SUB_W-1:0] sub_y_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             ndr_i,
  output logic             rd_sync_o,
  output logic             rst_sync_o,
  output logic             row_clk_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [ROW_W-1:0] rst_row_o,
  output logic             rst_en_o,
  output logic             blank_o,
  output logic             pix_valid_o,
  output logic [COL_W-1:0] pix_col_o,
  output logic             eol_o,
  output logic             eof_o
);
  cfg_t             cfg_live, cfg_q;
  logic             frame_load, line_adv, last_line, line_end, pix_raw;
  logic [COL_W-1:0] col_raw;
  logic [ROW_W-1:0] use_start, use_int;
  logic [SUB_W-1:0] use_sub_y;
  logic             rst_act;
  tag_t             tag_raw, tag_dly;

  always_comb begin
    cfg_live.row_start = row_start_i;
    cfg_live.row_count = (row_count_i == '0) ? ROW_W'(1) : row_count_i;
    cfg_live.int_lines = int_lines_i;
    cfg_live.col_start = col_start_i;
    if (col_count_i == '0)        cfg_live.col_count = COL_W'(1);
    else if (col_count_i > COL_MAX) cfg_live.col_count = COL_MAX;
    else                          cfg_live.col_count = col_count_i;
    cfg_live.sub_x = sub_x_i;
    cfg_live.sub_y = sub_y_i;
    cfg_live.delay = delay_i;
    cfg_live.ndr   = ndr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q           <= '0;
      cfg_q.col_count <= COL_RST;
    end else if (frame_load) begin
      cfg_q <= cfg_live;
    end
  end

  // values seen by pointer loads in the frame-start cycle
  assign use_start = frame_load ? cfg_live.row_start : cfg_q.row_start;
  assign use_int   = frame_load ? cfg_live.int_lines : cfg_q.int_lines;
  assign use_sub_y = frame_load ? cfg_live.sub_y     : cfg_q.sub_y;

  rs_line_timer #(.BLANK_CYC(BLANK_CYC), .PIX_LAT(PIX_LAT)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .last_line_i  (last_line),
    .col_start_i  (cfg_q.col_start),
    .col_last_i   (cfg_q.col_count - 1'b1),
    .step_x_i     (step_of(cfg_q.sub_x)),
    .frame_load_o (frame_load),
    .line_adv_o   (line_adv),
    .row_clk_o    (row_clk_o),
    .rd_sync_o    (rd_sync_o),
    .blank_o      (blank_o),
    .pix_o        (pix_raw),
    .line_end_o   (line_end),
    .col_o        (col_raw)
  );

  rs_row_ptrs u_ptrs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_adv_i   (line_adv),
    .frame_load_i (frame_load),
    .start_i      (use_start),
    .int_i        (use_int),
    .row_last_i   (cfg_q.row_count - 1'b1),
    .step_i       (step_of(use_sub_y)),
    .last_line_o  (last_line),
    .rd_row_o     (rd_row_o),
    .rst_row_o    (rst_row_o),
    .rst_act_o    (rst_act),
    .rst_sync_o   (rst_sync_o)
  );

  always_comb begin
    tag_raw.pv  = pix_raw;
    tag_raw.eol = line_end;
    tag_raw.eof = line_end & last_line;
    tag_raw.col = col_raw;
  end

  rs_out_delay u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cfg_q.delay),
    .tag_i  (tag_raw),
    .tag_o  (tag_dly)
  );

  assign pix_valid_o = tag_dly.pv;
  assign eol_o       = tag_dly.eol;
  assign eof_o       = tag_dly.eof;
  assign pix_col_o   = tag_dly.col;
  assign rst_en_o    = rst_act & ~cfg_q.ndr;
endmodule

// File: rtl/rs_seq_checker.sv
module rs_seq_checker import rs_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             row_clk,
  input logic             rd_sync,
  input logic             rst_sync,
  input logic             blank,
  input logic             pix_valid,
  input logic             eol,
  input logic             eof,
  input logic [ROW_W-1:0] rd_row,
  input logic [ROW_W-1:0] rst_row,
  input logic [ROW_W-1:0] cfg_start
);
  assert_sync_on_row_clk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sync |-> row_clk);
  assert_row_clk_in_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_clk |-> blank);
  assert_sync_loads_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sync |-> rd_row == cfg_start);
  assert_rd_row_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_clk |-> $stable(rd_row));
  assert_rst_loads_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sync |-> rst_row == cfg_start);
  assert_rst_row_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_clk |-> $stable(rst_row));
  assert_eof_with_eol_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof |-> eol);
  assert_eol_is_pixel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol |-> pix_valid);
endmodule

bind rolling_shutter_seq rs_seq_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .row_clk   (row_clk_o),
  .rd_sync   (rd_sync_o),
  .rst_sync  (rst_sync_o),
  .blank     (blank_o),
  .pix_valid (pix_valid_o),
  .eol       (eol_o),
  .eof       (eof_o),
  .rd_row    (rd_row_o),
  .rst_row   (rst_row_o),
  .cfg_start (cfg_q.row_start)
);

// File: tb/rolling_shutter_seq_test.sv
module rolling_shutter_seq_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BC = 8;
  localparam int PL = 5;

  typedef struct packed {
    logic [11:0] rs; logic [11:0] rc; logic [10:0] cs; logic [10:0] cc;
    logic [11:0] it; logic [2:0] sx; logic [2:0] sy; logic [3:0] dl; logic ndr;
    logic [10:0] e_px; logic [11:0] e_ln; logic [3:0] e_sx; logic [3:0] e_sy;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{12'd10,   12'd4, 11'd100,  11'd16,   12'd1, 3'd0, 3'd0, 4'd0,  1'b0, 11'd16,   12'd4, 4'd1, 4'd1},
    '{12'd4090, 12'd5, 11'd2000, 11'd6,    12'd2, 3'd3, 3'd2, 4'd3,  1'b0, 11'd6,    12'd5, 4'd8, 4'd4},
    '{12'd0,    12'd3, 11'd5,    11'd0,    12'd0, 3'd1, 3'd1, 4'd15, 1'b1, 11'd1,    12'd3, 4'd2, 4'd2},
    '{12'd7,    12'd1, 11'd0,    11'd2047, 12'd5, 3'd5, 3'd7, 4'd1,  1'b0, 11'd1111, 12'd1, 4'd1, 4'd1},
    '{12'd1,    12'd0, 11'd3,    11'd3,    12'd0, 3'd2, 3'd3, 4'd2,  1'b0, 11'd3,    12'd1, 4'd4, 4'd8}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, run_i = 1'b0, ndr_i = 1'b0;
  logic [11:0] row_start_i = '0, row_count_i = '0, int_lines_i = '0;
  logic [10:0] col_start_i = '0, col_count_i = '0;
  logic [2:0]  sub_x_i = '0, sub_y_i = '0;
  logic [3:0]  delay_i = '0;
  logic rd_sync_o, rst_sync_o, row_clk_o, rst_en_o, blank_o, pix_valid_o, eol_o, eof_o;
  logic [11:0] rd_row_o, rst_row_o;
  logic [10:0] pix_col_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rolling_shutter_seq #(.BLANK_CYC(BC), .PIX_LAT(PL)) uut (.*);

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check_quiet(input string req);
    cmp({req, " row_clk"}, int'(row_clk_o), 0);
    cmp({req, " rd_sync"}, int'(rd_sync_o), 0);
    cmp({req, " blank"}, int'(blank_o), 0);
    cmp({req, " pv"}, int'(pix_valid_o), 0);
    cmp({req, " eof"}, int'(eof_o), 0);
    cmp({req, " rd_row"}, int'(rd_row_o), 0);
    cmp({req, " rst_en"}, int'(rst_en_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    run_i  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check_quiet("R1 in reset");
    end
    run_i  = 1'b0;
    rst_ni = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i);
      check_quiet("R1 idle");
    end
  endtask

  task automatic apply(input vec_t v);
    row_start_i = v.rs; row_count_i = v.rc; col_start_i = v.cs; col_count_i = v.cc;
    int_lines_i = v.it; sub_x_i = v.sx; sub_y_i = v.sy; delay_i = v.dl; ndr_i = v.ndr;
  endtask

  task automatic wait_sync(input string req);
    int w = 0;
    do begin
      @(negedge clk_i);
      w++;
    end while (!rd_sync_o && w < 50);
    cmp({req, " frame start"}, int'(rd_sync_o), 1);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int px = int'(v.e_px), ln = int'(v.e_ln), dl = int'(v.dl), it = int'(v.it);
    int P = BC + PL + px;
    int T = ln * P;
    string tg;
    do_reset();
    apply(v);
    run_i = 1'b1;
    wait_sync($sformatf("R5 v%0d", idx));
    for (int n = 0; n <= T + dl + 4; n++) begin
      int pos = n % P, l = n / P, m = n - dl;
      int e_pv = 0, k = 0, lm = 0;
      if (n > 0) @(negedge clk_i);
      tg = $sformatf("v%0d n%0d", idx, n);
      if (m >= 0 && m < T && (m % P) >= BC + PL) begin
        e_pv = 1; k = (m % P) - (BC + PL); lm = m / P;
      end
      cmp({"R2 R12 row_clk ", tg}, int'(row_clk_o), int'(n < T && pos == 0));
      cmp({"R5 rd_sync ", tg}, int'(rd_sync_o), int'(n == 0));
      cmp({"R2 blank ", tg}, int'(blank_o), int'(n < T && pos < BC));
      cmp({"R3 R7 R10 pv ", tg}, int'(pix_valid_o), e_pv);
      cmp({"R6 eol ", tg}, int'(eol_o), int'(e_pv == 1 && k == px - 1));
      cmp({"R6 eof ", tg}, int'(eof_o), int'(e_pv == 1 && k == px - 1 && lm == ln - 1));
      cmp({"R8 rst_sync ", tg}, int'(rst_sync_o), int'(n < T && pos == 0 && it < ln && l == it));
      if (e_pv == 1)
        cmp({"R4 col ", tg}, int'(pix_col_o), (int'(v.cs) + k * int'(v.e_sx)) % 2048);
      if (n < T && pos == 0) begin
        cmp({"R5 rd_row ", tg}, int'(rd_row_o), (int'(v.rs) + l * int'(v.e_sy)) % 4096);
        cmp({"R9 rst_en ", tg}, int'(rst_en_o), int'(it < ln && l >= it && !v.ndr));
        if (it < ln && l >= it)
          cmp({"R8 rst_row ", tg}, int'(rst_row_o), (int'(v.rs) + (l - it) * int'(v.e_sy)) % 4096);
      end
      if (n == 2) begin
        // R11: mid-frame edits must not reach this frame; R12: run drop ends after it
        row_start_i = v.rs ^ 12'h5a5; row_count_i = v.rc + 12'd7; col_start_i = v.cs ^ 11'h2a;
        col_count_i = v.cc + 11'd9; int_lines_i = v.it + 12'd1; sub_x_i = v.sx + 3'd1;
        sub_y_i = v.sy + 3'd1; delay_i = v.dl + 4'd3; ndr_i = ~v.ndr;
        run_i = 1'b0;
      end
    end
  endtask

  initial begin
    // vector table: R2..R11 per configuration
    for (int i = 0; i < 5; i++) run_vec(VECS[i], i);

    // R12: continuous run restarts the frame right after the last pixel
    begin
      int gap = 0;
      do_reset();
      apply(VECS[0]);
      run_i = 1'b1;
      wait_sync("R12 cont");
      do begin
        @(negedge clk_i);
        gap++;
      end while (!rd_sync_o && gap < 400);
      cmp("R12 frame period", gap, 4 * (BC + PL + 16));
      cmp("R12 rd_row after wrap", int'(rd_row_o), 10);
      run_i = 1'b0;
      for (int i = 0; i < 4 * (BC + PL + 16) + 4; i++) @(negedge clk_i);
      cmp("R12 idle row_clk", int'(row_clk_o), 0);
      cmp("R12 idle blank", int'(blank_o), 0);
    end

    // R1: asynchronous reset inside a pixel window
    do_reset();
    apply(VECS[0]);
    run_i = 1'b1;
    wait_sync("R1 mid");
    for (int i = 0; i < 20; i++) @(negedge clk_i);
    cmp("R1 pv before reset", int'(pix_valid_o), 1);
    rst_ni = 1'b0;
    #1;
    check_quiet("R1 async");
    run_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_quiet("R1 after");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule